// File: doc/BRIEF.md
# Switchable ISA-Identity CSR Unit

This block holds a writable vendor/architecture identity pair for one hart and uses it to choose which of several instruction-decode engines is live. A fixed table, set at elaboration, lists the supported pairs. Each pair owns a slot. The active slot drives a one-hot enable bus, and each decode engine ANDs its bit into all of its encoding matches. The identity CSR is write-any-read-legal: writing a pair from the table activates its slot, and writing any other value leaves the current identity in place.

Each slot also owns its own machine-level and supervisor-level trap vector. Software reads and writes the vector CSRs, and those accesses always reach the entries of the active slot. A trap request returns the target taken from the active slot's entry. An identity change swaps the decode enable and the vector bank at the same clock edge. After that edge the block raises stall for one cycle. A trap that arrives in that cycle is held and then sent to the new identity's vector. A trap never changes the identity, so a handler can read the identity, save it and restore it later.

Top module: `isa_ident_csr`

## Requirements
- R1: After reset, slot 0 is active, `dec_en` is 4'b0001, `stall` and `trap_take` are low, and every vector entry reads as zero.
- R2: CSR address 0x7C0 reads the active slot's pair as {vendor[31:16], arch[15:0]}. A write of a pair from the table (default slots 0..3: 0x0A110001, 0x0A110002, 0x5EED0001, 0xF0E10007) makes that slot active at the next edge.
- R3: `dec_en` always has exactly one bit set, and that bit's index is the active slot.
- R4: A write to 0x7C0 of a value that is not in the table is ignored: the identity, `dec_en` and `stall` stay unchanged.
- R5: CSR address 0x7C1 (machine vector) and 0x7C2 (supervisor vector) access the active slot's entry. Bits [1:0] are not stored and read as zero. `csr_rdata` is registered and shows the addressed value one cycle after `csr_addr`.
- R6: `trap_req` taken outside a stall gives `trap_take` high in the next cycle. `trap_target` comes from the active slot's entry for the level chosen by `trap_sup` (0 machine, 1 supervisor). A trap never changes the identity.
- R7: An accepted identity write raises `stall` for exactly one cycle. `dec_en` and the vector bank change at the same edge that raises `stall`.
- R8: A `trap_req` seen while `stall` is high is held. `trap_take` rises two cycles later, and the target comes from the new identity's vector.
- R9: When a `trap_req` and an identity write come in the same cycle, the write is dropped and the trap uses the old identity's vector.
- R10: CSR writes presented while `stall` is high are ignored.
- R11: Each slot keeps its own vector entries across identity changes. Switching back to a slot returns its earlier vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | CSR address for read and write |
| csr_we | input | 1 | CSR write strobe |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | Registered CSR read data |
| trap_req | input | 1 | Trap request pulse |
| trap_sup | input | 1 | Trap level: 0 machine, 1 supervisor |
| trap_take | output | 1 | Trap accepted, target valid |
| trap_target | output | 32 | Trap vector of the active identity |
| dec_en | output | 4 | One-hot decode-engine enable |
| stall | output | 1 | Pipeline hold during an identity switch |

## Verification
The properties assume that `trap_req` is a single-cycle pulse. They also assume that no fresh request arrives in the cycle in which a held trap is serviced, because the block merges such a request into the held one. The stimulus drives each trap for one cycle only, and after a stall-cycle trap it waits for `trap_take` before it raises anything else. The properties also assume that the slot table has no duplicate pairs. The default table holds four distinct pairs, and every test uses that default table.

// File: rtl/isa_ident_pkg.sv
package isa_ident_pkg;
  localparam int XLEN   = 32;
  localparam int ID_W   = 16;
  localparam int NSLOT  = 4;
  localparam int CSR_AW = 12;

  localparam logic [CSR_AW-1:0] A_IDENT = 12'h7C0;
  localparam logic [CSR_AW-1:0] A_MVEC  = 12'h7C1;
  localparam logic [CSR_AW-1:0] A_SVEC  = 12'h7C2;

  // slot 0 in the low word
  localparam logic [NSLOT*XLEN-1:0] DEF_TUPLES =
    {32'hF0E1_0007, 32'h5EED_0001, 32'h0A11_0002, 32'h0A11_0001};

  typedef enum logic {LVL_M = 1'b0, LVL_S = 1'b1} trap_lvl_e;
endpackage

// File: rtl/isa_tuple_match.sv
module isa_tuple_match #(
  parameter int NUM_SLOTS = 4,
  parameter int XLEN      = 32,
  parameter int SLOT_W    = 2,
  parameter logic [NUM_SLOTS*XLEN-1:0] TUPLES = '0
) (
  input  logic [XLEN-1:0]   tuple_i,
  input  logic [SLOT_W-1:0] idx_i,
  output logic              hit_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [XLEN-1:0]   tuple_at_idx_o
);
  logic [NUM_SLOTS-1:0] match;

  genvar g;
  generate
    for (g = 0; g < NUM_SLOTS; g++) begin : g_cmp
      assign match[g] = (tuple_i == TUPLES[g*XLEN +: XLEN]);
    end
  endgenerate

  always_comb begin
    slot_o = '0;
    for (int i = NUM_SLOTS-1; i >= 0; i--) begin
      if (match[i]) slot_o = SLOT_W'(i);
    end
  end

  assign hit_o          = |match;
  assign tuple_at_idx_o = TUPLES[idx_i*XLEN +: XLEN];
endmodule

// File: rtl/isa_vec_bank.sv
module isa_vec_bank #(
  parameter int DEPTH  = 4,
  parameter int W      = 30,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SLOT_W-1:0] slot,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata
);
  // storage carries no reset; a per-entry written flag masks stale data
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] written_q;

  always_ff @(posedge clk) begin
    if (we) mem[slot] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) written_q <= '0;
    else if (we) written_q[slot] <= 1'b1;
  end

  assign rdata = written_q[slot] ? mem[slot] : '0;
endmodule

// File: rtl/isa_switch_ctrl.sv
module isa_switch_ctrl #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ident_wr,
  input  logic                 hit,
  input  logic [SLOT_W-1:0]    hit_slot,
  input  logic                 trap_req,
  input  logic                 trap_sup,
  output logic [SLOT_W-1:0]    slot_q,
  output logic                 stall_q,
  output logic [NUM_SLOTS-1:0] dec_en_q,
  output logic                 svc,
  output logic                 svc_sup,
  output logic                 take_q
);
  logic pend_q, pend_sup_q, switch_go;
  logic [SLOT_W-1:0] slot_d;

  assign svc       = pend_q | (trap_req & ~stall_q);
  assign svc_sup   = pend_q ? pend_sup_q : trap_sup;
  // a trap in the same cycle wins over the identity write
  assign switch_go = ident_wr & hit & ~svc;
  assign slot_d    = switch_go ? hit_slot : slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q     <= '0;
      stall_q    <= 1'b0;
      dec_en_q   <= NUM_SLOTS'(1);
      pend_q     <= 1'b0;
      pend_sup_q <= 1'b0;
      take_q     <= 1'b0;
    end else begin
      slot_q     <= slot_d;
      stall_q    <= switch_go;
      dec_en_q   <= NUM_SLOTS'(1) << slot_d;
      pend_q     <= stall_q & trap_req;
      pend_sup_q <= trap_sup;
      take_q     <= svc;
    end
  end
endmodule

// File: rtl/isa_ident_csr.sv
module isa_ident_csr
  import isa_ident_pkg::*;
#(
  parameter int NUM_SLOTS = NSLOT,
  parameter logic [NUM_SLOTS*XLEN-1:0] TUPLES = DEF_TUPLES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CSR_AW-1:0]    csr_addr,
  input  logic                 csr_we,
  input  logic [XLEN-1:0]      csr_wdata,
  output logic [XLEN-1:0]      csr_rdata,
  input  logic                 trap_req,
  input  logic                 trap_sup,
  output logic                 trap_take,
  output logic [XLEN-1:0]      trap_target,
  output logic [NUM_SLOTS-1:0] dec_en,
  output logic                 stall
);
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int VW     = XLEN - 2;

  logic [SLOT_W-1:0] slot_q, hit_slot;
  logic              hit, wr_ok, svc, svc_sup;
  logic [XLEN-1:0]   cur_tuple;
  logic [VW-1:0]     vec_rd [2];
  wire               unused_low = ^csr_wdata[1:0];

  assign wr_ok = csr_we & ~stall;

  isa_tuple_match #(
    .NUM_SLOTS(NUM_SLOTS), .XLEN(XLEN), .SLOT_W(SLOT_W), .TUPLES(TUPLES)
  ) u_match (
    .tuple_i(csr_wdata), .idx_i(slot_q), .hit_o(hit),
    .slot_o(hit_slot), .tuple_at_idx_o(cur_tuple)
  );

  isa_switch_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .ident_wr(wr_ok && csr_addr == A_IDENT),
    .hit(hit), .hit_slot(hit_slot),
    .trap_req(trap_req), .trap_sup(trap_sup),
    .slot_q(slot_q), .stall_q(stall), .dec_en_q(dec_en),
    .svc(svc), .svc_sup(svc_sup), .take_q(trap_take)
  );

  genvar l;
  generate
    for (l = 0; l < 2; l++) begin : g_lvl
      localparam logic [CSR_AW-1:0] ADDR = (l == 0) ? A_MVEC : A_SVEC;
      isa_vec_bank #(.DEPTH(NUM_SLOTS), .W(VW), .SLOT_W(SLOT_W)) u_bank (
        .clk(clk), .rst(rst),
        .we(wr_ok && csr_addr == ADDR),
        .slot(slot_q), .wdata(csr_wdata[XLEN-1:2]),
        .rdata(vec_rd[l])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_target <= '0;
    end else if (svc) begin
      trap_target <= {vec_rd[svc_sup ? 1 : 0], 2'b00};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata <= '0;
    end else begin
      case (csr_addr)
        A_IDENT: csr_rdata <= cur_tuple;
        A_MVEC:  csr_rdata <= {vec_rd[0], 2'b00};
        A_SVEC:  csr_rdata <= {vec_rd[1], 2'b00};
        default: csr_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/isa_ident_csr_chk.sv
module isa_ident_csr_chk
  import isa_ident_pkg::*;
#(
  parameter int NUM_SLOTS = NSLOT
) (
  input logic                 clk,
  input logic                 rst,
  input logic [CSR_AW-1:0]    csr_addr,
  input logic                 csr_we,
  input logic                 trap_req,
  input logic                 trap_take,
  input logic [NUM_SLOTS-1:0] dec_en,
  input logic                 stall
);
  p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(dec_en) == 1);

  p_trap_keeps_ident_r6: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !stall) |=> $stable(dec_en));

  p_stall_single_r7: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  p_switch_stalls_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(dec_en) |-> stall);

  p_held_trap_r8: assert property (@(posedge clk) disable iff (rst)
    (stall && trap_req) |=> (!trap_take ##1 trap_take));

  p_trap_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !stall && csr_we && csr_addr == A_IDENT)
      |=> (!stall && $stable(dec_en)));

  p_stall_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(dec_en));
endmodule

bind isa_ident_csr isa_ident_csr_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_we(csr_we),
  .trap_req(trap_req), .trap_take(trap_take), .dec_en(dec_en), .stall(stall)
);

// File: tb/isa_ident_csr_test.sv
module isa_ident_csr_test;
  import isa_ident_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] csr_addr = '0;
  logic csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic trap_req = 1'b0;
  logic trap_sup = 1'b0;
  logic trap_take;
  logic [31:0] trap_target;
  logic [3:0] dec_en;
  logic stall;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  isa_ident_csr uut (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .trap_req(trap_req),
    .trap_sup(trap_sup), .trap_take(trap_take), .trap_target(trap_target),
    .dec_en(dec_en), .stall(stall)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    csr_addr = a;
    @(negedge clk);
    d = csr_rdata;
  endtask

  task automatic trap(input logic sup, input logic [31:0] exp, input string req);
    trap_req = 1'b1; trap_sup = sup;
    @(negedge clk);
    trap_req = 1'b0;
    chk({req, " take"}, {31'd0, trap_take}, 32'd1);
    chk({req, " target"}, trap_target, exp);
  endtask

  task automatic switch_to(input logic [31:0] t, input logic [3:0] en);
    wr(A_IDENT, t);
    chk("R7 stall raised", {31'd0, stall}, 32'd1);
    chk("R3 dec_en after switch", {28'd0, dec_en}, {28'd0, en});
    @(negedge clk);
    chk("R7 stall one cycle", {31'd0, stall}, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 dec_en", {28'd0, dec_en}, 32'h1);
    chk("R1 stall", {31'd0, stall}, 32'd0);
    chk("R1 trap_take", {31'd0, trap_take}, 32'd0);
    rd(A_IDENT, v); chk("R1 R2 ident", v, 32'h0A11_0001);
    rd(A_MVEC, v);  chk("R1 mvec zero", v, 32'd0);
    rd(A_SVEC, v);  chk("R1 svec zero", v, 32'd0);
  endtask

  task automatic t_vectors_slot0();
    logic [31:0] v;
    wr(A_MVEC, 32'h1000_0103);
    wr(A_SVEC, 32'h2000_0202);
    rd(A_MVEC, v); chk("R5 mvec low bits", v, 32'h1000_0100);
    rd(A_SVEC, v); chk("R5 svec low bits", v, 32'h2000_0200);
    trap(1'b0, 32'h1000_0100, "R6 machine trap");
    trap(1'b1, 32'h2000_0200, "R6 supervisor trap");
    chk("R6 ident kept", {28'd0, dec_en}, 32'h1);
  endtask

  task automatic t_switch_slot2();
    logic [31:0] v;
    switch_to(32'h5EED_0001, 4'b0100);
    rd(A_IDENT, v); chk("R2 ident slot2", v, 32'h5EED_0001);
    rd(A_MVEC, v);  chk("R7 new bank empty", v, 32'd0);
    wr(A_MVEC, 32'h3000_0040);
    trap(1'b0, 32'h3000_0040, "R6 slot2 trap");
  endtask

  task automatic t_unsupported();
    logic [31:0] v;
    wr(A_IDENT, 32'h1234_5678);
    chk("R4 no stall", {31'd0, stall}, 32'd0);
    chk("R4 dec_en kept", {28'd0, dec_en}, 32'h4);
    rd(A_IDENT, v); chk("R4 ident kept", v, 32'h5EED_0001);
  endtask

  task automatic t_trap_wins();
    logic [31:0] v;
    csr_addr = A_IDENT; csr_wdata = 32'h0A11_0002; csr_we = 1'b1;
    trap_req = 1'b1; trap_sup = 1'b0;
    @(negedge clk);
    csr_we = 1'b0; trap_req = 1'b0;
    chk("R9 take", {31'd0, trap_take}, 32'd1);
    chk("R9 old vector", trap_target, 32'h3000_0040);
    chk("R9 no stall", {31'd0, stall}, 32'd0);
    chk("R9 dec_en kept", {28'd0, dec_en}, 32'h4);
    rd(A_IDENT, v); chk("R9 ident kept", v, 32'h5EED_0001);
  endtask

  task automatic t_trap_in_stall();
    logic [31:0] v;
    wr(A_IDENT, 32'hF0E1_0007);
    chk("R7 stall slot3", {31'd0, stall}, 32'd1);
    chk("R3 dec_en slot3", {28'd0, dec_en}, 32'h8);
    csr_addr = A_SVEC; csr_wdata = 32'hDEAD_BEEC; csr_we = 1'b1;
    trap_req = 1'b1; trap_sup = 1'b1;
    @(negedge clk);
    csr_we = 1'b0; trap_req = 1'b0;
    chk("R8 held one cycle", {31'd0, trap_take}, 32'd0);
    @(negedge clk);
    chk("R8 held take", {31'd0, trap_take}, 32'd1);
    chk("R8 R10 new vector", trap_target, 32'd0);
    rd(A_SVEC, v); chk("R10 write in stall ignored", v, 32'd0);
  endtask

  task automatic t_restore();
    logic [31:0] v;
    switch_to(32'h0A11_0001, 4'b0001);
    rd(A_MVEC, v); chk("R11 mvec kept", v, 32'h1000_0100);
    rd(A_SVEC, v); chk("R11 svec kept", v, 32'h2000_0200);
    trap(1'b1, 32'h2000_0200, "R11 trap after return");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_vectors_slot0();
    t_switch_slot2();
    t_unsupported();
    t_trap_wins();
    t_trap_in_stall();
    t_restore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule